// File: doc/BRIEF.md
# Palette Lookup with Overlay Selection

This block converts one pixel per clock into a 24-bit color. Each pixel arrives as an 8-bit palette index, a 2-bit overlay code, an active flag and the current blink phase. The block then returns red, green and blue bytes plus a blank qualifier.

Before the lookup, the index passes through two bit-plane masks. The read mask clears index bits outright. The blink mask clears its bits only while the blink phase is low.

An overlay enable bit decides where the color comes from. When it is set, the color is taken from one of four overlay registers, chosen by the overlay code. When it is clear, the color comes from the 256-entry palette.

A blank pixel gives a zero color with the blank qualifier raised. A single host write port loads the palette, the overlay registers and a control word.

Top module: `color_lut_overlay`

## Requirements
- R1: An active pixel with overlay enable clear outputs the palette entry at the masked index. Red is bits 23:16 of the entry, green is bits 15:8 and blue is bits 7:0. The result appears two clocks after the pixel is sampled, with blank_out low.
- R2: Each index bit is ANDed with the matching read-mask bit before the lookup.
- R3: While blink_phase is low, any index bit whose blink-mask bit is set is forced to zero. While blink_phase is high, the blink mask has no effect.
- R4: With overlay enable set, an active pixel outputs overlay register number ovl_code, for every code 0 to 3. The pixel index has no effect on the result.
- R5: With overlay enable clear, the overlay code has no effect on the result.
- R6: A pixel sampled with pix_active low outputs a zero color with blank_out high, two clocks later. Neither its index nor its overlay code affects the result.
- R7: In reset and after it, the outputs are zero color with blank_out high. After reset the read mask is 0xFF, the blink mask is 0x00 and overlay enable is clear.
- R8: The host write port takes one write per clock while wr_en is high, with the target chosen by wr_tgt:
  - wr_tgt 0 writes palette entry wr_addr.
  - wr_tgt 1 writes overlay register wr_addr[1:0].
  - wr_tgt 2 writes the control word: read mask from wr_data[7:0], blink mask from wr_data[15:8] and overlay enable from wr_data[16].
  - wr_tgt 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_tgt | input | 2 | Write target: 0 palette, 1 overlay, 2 control, 3 none |
| wr_addr | input | 8 | Palette entry or overlay register number |
| wr_data | input | 24 | Write data |
| pix_idx | input | 8 | Pixel palette index |
| ovl_code | input | 2 | Pixel overlay code |
| pix_active | input | 1 | High for a visible pixel, low to blank |
| blink_phase | input | 1 | Current blink phase, high means blinked bits shown |
| red | output | 8 | Red component |
| green | output | 8 | Green component |
| blue | output | 8 | Blue component |
| blank_out | output | 1 | High when the output pixel is blanked |

## Verification
A corrupted mask or enable register shows up at the ports two clocks after the next active pixel. It appears as a wrong palette entry or as an overlay color in place of a palette color. A stale or misaddressed palette or overlay write shows up only when a pixel selects that entry, so the bench first sweeps every palette entry and overlay register. It then mixes random pixels and random control words with directed mask and blank cases.

// File: rtl/color_lut_overlay.sv
module color_lut_overlay #(
  parameter int IDXW = 8,
  parameter int CW   = 8,
  parameter int OVW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_tgt,
  input  logic [IDXW-1:0]   wr_addr,
  input  logic [3*CW-1:0]   wr_data,
  input  logic [IDXW-1:0]   pix_idx,
  input  logic [OVW-1:0]    ovl_code,
  input  logic              pix_active,
  input  logic              blink_phase,
  output logic [CW-1:0]     red,
  output logic [CW-1:0]     green,
  output logic [CW-1:0]     blue,
  output logic              blank_out
);
  localparam int DEPTH = 1 << IDXW;
  localparam int NOVL  = 1 << OVW;
  localparam int WW    = 3 * CW;

  logic [WW-1:0]   pal [DEPTH];
  logic [WW-1:0]   ovl [NOVL];
  logic [IDXW-1:0] rmask, bmask;
  logic            oen;

  logic [IDXW-1:0] s1_idx;
  logic [OVW-1:0]  s1_code;
  logic            s1_ovl, s1_act;
  logic [WW-1:0]   color;

  wire [IDXW-1:0] blink_clr = blink_phase ? '0 : bmask;
  wire [IDXW-1:0] masked    = pix_idx & rmask & ~blink_clr;

  always_ff @(posedge clk)
    if (wr_en && wr_tgt == 2'd0) pal[wr_addr] <= wr_data;

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < NOVL; i++) ovl[i] <= '0;
      rmask <= '1;
      bmask <= '0;
      oen   <= 1'b0;
    end else if (wr_en) begin
      if (wr_tgt == 2'd1) ovl[wr_addr[OVW-1:0]] <= wr_data;
      if (wr_tgt == 2'd2) begin
        rmask <= wr_data[IDXW-1:0];
        bmask <= wr_data[2*IDXW-1:IDXW];
        oen   <= wr_data[2*IDXW];
      end
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      s1_idx  <= '0;
      s1_code <= '0;
      s1_ovl  <= 1'b0;
      s1_act  <= 1'b0;
    end else begin
      s1_idx  <= masked;
      s1_code <= ovl_code;
      s1_ovl  <= oen;
      s1_act  <= pix_active;
    end

  always_ff @(posedge clk)
    if (!rst_n || !s1_act) begin
      color     <= '0;
      blank_out <= 1'b1;
    end else begin
      color     <= s1_ovl ? ovl[s1_code] : pal[s1_idx];
      blank_out <= 1'b0;
    end

  assign red   = color[3*CW-1:2*CW];
  assign green = color[2*CW-1:CW];
  assign blue  = color[CW-1:0];

  a_r2_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_idx & ~$past(rmask)) == '0);

  a_r3_blink_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(blink_phase) |-> (s1_idx & $past(bmask)) == '0);

  a_r6_blank_level: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_active |-> ##2 (blank_out && red == '0 && green == '0 && blue == '0));

  a_r8_ignored_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tgt == 2'd3) |=> ($stable(rmask) && $stable(bmask) && $stable(oen)));
endmodule

// File: tb/tb_color_lut_overlay.sv
`timescale 1ns/1ps
module tb_color_lut_overlay;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_tgt = 0;
  logic [7:0] wr_addr = 0;
  logic [23:0] wr_data = 0;
  logic [7:0] pix_idx = 0;
  logic [1:0] ovl_code = 0;
  logic pix_active = 0, blink_phase = 1;
  logic [7:0] red, green, blue;
  logic blank_out;

  color_lut_overlay dut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [23:0] m_pal [256];
  logic [23:0] m_ovl [4];
  logic [7:0]  m_rm = 8'hFF, m_bm = 8'h00;
  logic        m_en = 0;

  logic [24:0] pipe0, pipe1;
  string tag0, tag1;
  bit v0 = 0, v1 = 0;

  function automatic logic [23:0] pal_val(int i);
    return 24'((i * 32'h9E3779) ^ (i << 13) ^ 32'h5A3C1F);
  endfunction

  function automatic logic [24:0] model(logic [7:0] idx, logic [1:0] code, logic act, logic bl);
    logic [7:0] mi;
    if (!act) return {1'b1, 24'h0};
    mi = idx & m_rm & ~(bl ? 8'h00 : m_bm);
    if (m_en) return {1'b0, m_ovl[code]};
    return {1'b0, m_pal[mi]};
  endfunction

  task automatic check(string tag, logic [24:0] exp);
    checks++;
    if ({blank_out, red, green, blue} !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, {blank_out, red, green, blue}, exp);
    end
  endtask

  task automatic step(logic [7:0] idx, logic [1:0] code, logic act, logic bl, string tag,
                      logic we = 0, logic [1:0] tgt = 0, logic [7:0] a = 0, logic [23:0] d = 0);
    @(negedge clk);
    if (v1) check(tag1, pipe1);
    pipe1 = pipe0; v1 = v0; tag1 = tag0;
    pix_idx = idx; ovl_code = code; pix_active = act; blink_phase = bl;
    wr_en = we; wr_tgt = tgt; wr_addr = a; wr_data = d;
    pipe0 = model(idx, code, act, bl); v0 = 1; tag0 = tag;
    if (we) begin
      case (tgt)
        2'd0: m_pal[a] = d;
        2'd1: m_ovl[a[1:0]] = d;
        2'd2: begin m_rm = d[7:0]; m_bm = d[15:8]; m_en = d[16]; end
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [1:0] tgt, logic [7:0] a, logic [23:0] d, string tag = "R8");
    step(8'h00, 2'd0, 1'b0, 1'b1, tag, 1'b1, tgt, a, d);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check("R7 reset", {1'b1, 24'h0});
    @(negedge clk); rst_n = 1;
    check("R7 after reset", {1'b1, 24'h0});
    for (int i = 0; i < 256; i++) wr(2'd0, 8'(i), pal_val(i));
    for (int i = 0; i < 4; i++) wr(2'd1, 8'(i), 24'hC0DE00 ^ (24'(i) * 24'h111111));
    step(8'hFF, 2'd3, 1'b1, 1'b0, "R7 default masks");
    for (int i = 0; i < 256; i++) step(8'(i), 2'(i), 1'b1, 1'b1, "R1 R5 palette sweep");
    wr(2'd3, 8'h00, 24'h010000, "R8 target 3 ignored");
    step(8'hA5, 2'd2, 1'b1, 1'b0, "R8 target 3 ignored");
    wr(2'd2, 8'h00, 24'h0000F0);
    step(8'hFF, 2'd0, 1'b1, 1'b1, "R2 read mask");
    step(8'h0F, 2'd0, 1'b1, 1'b1, "R2 read mask");
    wr(2'd2, 8'h00, 24'h00C3FF);
    step(8'hFF, 2'd0, 1'b1, 1'b0, "R3 blink off");
    step(8'hFF, 2'd0, 1'b1, 1'b1, "R3 blink on");
    wr(2'd2, 8'h00, 24'h0100FF);
    for (int i = 0; i < 4; i++) step(8'h37, 2'(i), 1'b1, 1'b1, "R4 overlay code");
    step(8'hC8, 2'd2, 1'b1, 1'b1, "R4 index ignored");
    step(8'hC8, 2'd2, 1'b0, 1'b1, "R6 blank overlay");
    wr(2'd2, 8'h00, 24'h0000FF);
    step(8'hC8, 2'd1, 1'b0, 1'b1, "R6 blank palette");
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 19) == 0)
        wr(2'd2, 8'h00, {7'h0, 1'($urandom_range(0, 3) == 0), 8'($urandom), 8'($urandom)});
      else if ($urandom_range(0, 29) == 0)
        wr(2'd1, 8'($urandom), 24'($urandom));
      else
        step(8'($urandom), 2'($urandom), $urandom_range(0, 7) != 0, 1'($urandom),
             "R1 R2 R3 R4 R5 R6 random");
    end
    step(8'h00, 2'd0, 1'b0, 1'b1, "R6 flush");
    step(8'h00, 2'd0, 1'b0, 1'b1, "R6 flush");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule